// File: doc/BRIEF.md
# SPI Identification Read Responder

This block is the part of an SPI serial memory slave that answers identification requests. It watches the chip-select, serial clock and serial input of the bus, collects an 8-bit instruction at the start of each frame and, for the two instruction families it owns, shifts identification bytes back on the serial output, most significant bit first. The bus is sampled in the block's own clock domain: `sck`, `cs_n` and `si` are treated as synchronous inputs, and clock edges of the bus are found by comparing `sck` with its value one cycle earlier.

The fixed-sequence read (instruction 9Fh) returns a manufacturer byte, a memory-type byte and a capacity byte, and then zeros for as long as the frame stays open. The addressed read (instructions 90h and ABh) first takes 24 address bits. It then alternates the manufacturer byte and the device byte without end. Address bit 0 picks which of the two comes first. Any other instruction leaves the output released for the rest of the frame. The output enable goes to a pad driver outside the block. It is low while bits are being received, while the frame is closed, and after an instruction the block does not handle.

The controller has five states: `ST_CMD` (collect the instruction), `ST_ADDR` (collect the address), `ST_JEDEC_TX` (fixed-sequence output), `ST_LEGACY_TX` (alternating output) and `ST_SKIP` (frame ignored). Raising `cs_n` in any state returns it to `ST_CMD`. In `ST_CMD`, the eighth received bit selects the next state: 9Fh goes to `ST_JEDEC_TX`, 90h or ABh goes to `ST_ADDR`, and any other value goes to `ST_SKIP`. In `ST_ADDR`, the 24th address bit moves the controller to `ST_LEGACY_TX`. Both output states, and `ST_SKIP`, hold until the frame ends.

Top module: `spi_id_responder`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `so_oe` is 0.
- R2: `so_oe` stays 0 while the instruction bits and the address bits are being received.
- R3: After instruction 9Fh, the output carries BFh, then 25h, then 8Dh, each shifted most significant bit first.
- R4: After the third byte of the 9Fh read, the output carries 00h bytes with `so_oe` high for as long as `cs_n` stays low.
- R5: Instructions 90h and ABh are each followed by 24 address bits, sent most significant bit first, before any output appears. When address bit 0 is 0, the first byte returned is BFh.
- R6: In the addressed read, when address bit 0 is 1, the first byte returned is 8Dh.
- R7: In the addressed read, the output alternates between BFh and 8Dh for as long as `cs_n` stays low.
- R8: In the addressed read, address bits 23 down to 1 have no effect on the bytes returned.
- R9: A rising `cs_n` drops `so_oe` in the same cycle, even part-way through a byte. The next frame starts fresh with instruction decoding.
- R10: An instruction other than 9Fh, 90h or ABh keeps `so_oe` at 0 until `cs_n` rises.
- R11: `so_out` changes only in the cycle after a falling `sck` edge is sampled. The first output bit appears at the falling edge that follows the last received bit. This holds in both SPI mode 0 (idle clock low) and mode 3 (idle clock high).
- R12: `si` is taken on rising `sck` edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, synchronous to `clk` |
| cs_n | input | 1 | SPI chip select, active low; frames the transfer |
| si | input | 1 | SPI serial data in |
| so_out | output | 1 | Serial data out, valid while `so_oe` is high |
| so_oe | output | 1 | Drive enable for the external output pad; 0 means high impedance |

## Verification
The 9Fh read is run with short frames and with frames several bytes long, so that the three-byte sequence and the zero tail that follows it are both seen. The addressed read uses both instruction codes. It is given addresses with bit 0 clear and set, and with the upper bits all ones or random, which separates start-byte selection and alternation from any use of the upper address bits. Unknown instructions, frames cut off in the middle of a byte, and frames alternating between mode 0 and mode 3 show that the output stays released and that each new frame is decoded from scratch. Random frames mix all of these with random read lengths.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_CMD       = 3'd0,
        ST_ADDR      = 3'd1,
        ST_JEDEC_TX  = 3'd2,
        ST_LEGACY_TX = 3'd3,
        ST_SKIP      = 3'd4
    } id_state_e;

    typedef enum logic {
        SEQ_JEDEC  = 1'b0,
        SEQ_LEGACY = 1'b1
    } seq_kind_e;

endpackage

// File: rtl/spi_sck_edges.sv
module spi_sck_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/spi_id_rx.sv
module spi_id_rx #(
    parameter int W     = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             si,
    output logic [W-1:0]     word,
    output logic [CNT_W-1:0] bit_cnt
);
    logic [W-2:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (shift_en) begin
            shreg   <= {shreg[W-3:0], si};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // word as it will stand once the bit arriving now is included
    assign word = {shreg, si};
endmodule

// File: rtl/id_byte_seq.sv
module id_byte_seq
    import spi_id_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_ID  = 8'hBF,
    parameter logic [BYTE_W-1:0] TYPE_ID = 8'h25,
    parameter logic [BYTE_W-1:0] CAP_ID  = 8'h8D,
    parameter logic [BYTE_W-1:0] DEV_ID  = 8'h8D
) (
    input  seq_kind_e         kind,
    input  logic [1:0]        jidx,
    input  logic              alt_dev,
    output logic [BYTE_W-1:0] byte_out
);
    always_comb begin
        byte_out = '0;
        unique case (kind)
            SEQ_JEDEC: begin
                unique case (jidx)
                    2'd0:    byte_out = MFR_ID;
                    2'd1:    byte_out = TYPE_ID;
                    2'd2:    byte_out = CAP_ID;
                    default: byte_out = '0;
                endcase
            end
            SEQ_LEGACY: byte_out = alt_dev ? DEV_ID : MFR_ID;
            default:    byte_out = '0;
        endcase
    end
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OP_JEDEC = 8'h9F,
    parameter logic [BYTE_W-1:0] OP_LEG_A = 8'h90,
    parameter logic [BYTE_W-1:0] OP_LEG_B = 8'hAB,
    parameter logic [BYTE_W-1:0] MFR_ID   = 8'hBF,
    parameter logic [BYTE_W-1:0] TYPE_ID  = 8'h25,
    parameter logic [BYTE_W-1:0] CAP_ID   = 8'h8D,
    parameter logic [BYTE_W-1:0] DEV_ID   = 8'h8D,
    parameter int                ADDR_BITS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so_out,
    output logic so_oe
);
    localparam int CNT_W = $clog2(ADDR_BITS);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);

    id_state_e state, state_next;

    logic              sck_rise, sck_fall;
    logic [BYTE_W-1:0] rx_word;
    logic [CNT_W-1:0]  rx_cnt;
    logic              rx_clear, rx_shift;
    logic              op_done, addr_done;
    logic              is_jedec, is_legacy;

    logic [BYTE_W-1:0] tx_q;
    logic [BIT_W-1:0]  bcnt_q;
    logic [1:0]        jidx_q;
    logic              alt_q;
    logic              so_q, oe_q;

    seq_kind_e         seq_kind;
    logic [1:0]        seq_idx;
    logic              seq_alt;
    logic [BYTE_W-1:0] seq_byte;

    spi_sck_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_id_rx #(.W(BYTE_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (rx_shift),
        .si       (si),
        .word     (rx_word),
        .bit_cnt  (rx_cnt)
    );

    id_byte_seq #(
        .MFR_ID  (MFR_ID),
        .TYPE_ID (TYPE_ID),
        .CAP_ID  (CAP_ID),
        .DEV_ID  (DEV_ID)
    ) u_seq (
        .kind     (seq_kind),
        .jidx     (seq_idx),
        .alt_dev  (seq_alt),
        .byte_out (seq_byte)
    );

    // receive-side decode
    assign op_done   = (state == ST_CMD)  && sck_rise && (rx_cnt == OP_LAST);
    assign addr_done = (state == ST_ADDR) && sck_rise && (rx_cnt == ADDR_LAST);
    assign is_jedec  = (rx_word == OP_JEDEC);
    assign is_legacy = (rx_word == OP_LEG_A) || (rx_word == OP_LEG_B);
    assign rx_shift  = sck_rise && ((state == ST_CMD) || (state == ST_ADDR));
    assign rx_clear  = cs_n || op_done;

    // transitions
    always_comb begin
        state_next = state;
        unique case (state)
            ST_CMD: begin
                if (op_done) begin
                    if (is_jedec)       state_next = ST_JEDEC_TX;
                    else if (is_legacy) state_next = ST_ADDR;
                    else                state_next = ST_SKIP;
                end
            end
            ST_ADDR:      if (addr_done) state_next = ST_LEGACY_TX;
            ST_JEDEC_TX:  state_next = ST_JEDEC_TX;
            ST_LEGACY_TX: state_next = ST_LEGACY_TX;
            ST_SKIP:      state_next = ST_SKIP;
            default:      state_next = ST_CMD;
        endcase
        if (cs_n) state_next = ST_CMD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_next;
    end

    // byte selection: first byte while decoding, next byte while sending
    always_comb begin
        seq_kind = SEQ_JEDEC;
        seq_idx  = jidx_q;
        seq_alt  = alt_q;
        unique case (state)
            ST_CMD:       seq_idx = 2'd0;
            ST_ADDR: begin
                seq_kind = SEQ_LEGACY;
                seq_alt  = si;
            end
            ST_LEGACY_TX: seq_kind = SEQ_LEGACY;
            default:      seq_kind = SEQ_JEDEC;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            bcnt_q <= '0;
            jidx_q <= '0;
            alt_q  <= 1'b0;
            so_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else if (cs_n) begin
            tx_q   <= '0;
            bcnt_q <= '0;
            jidx_q <= '0;
            alt_q  <= 1'b0;
            so_q   <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (op_done && is_jedec) begin
                tx_q   <= seq_byte;
                jidx_q <= 2'd1;
                bcnt_q <= '0;
            end
            if (addr_done) begin
                tx_q   <= seq_byte;
                alt_q  <= ~si;
                bcnt_q <= '0;
            end
            if (sck_fall && ((state == ST_JEDEC_TX) || (state == ST_LEGACY_TX))) begin
                so_q   <= tx_q[BYTE_W-1];
                oe_q   <= 1'b1;
                bcnt_q <= bcnt_q + 1'b1;
                if (bcnt_q == BIT_LAST) begin
                    tx_q  <= seq_byte;
                    alt_q <= ~alt_q;
                    if (jidx_q != 2'd3) jidx_q <= jidx_q + 2'd1;
                end else begin
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign so_out = so_q;
    assign so_oe  = oe_q & ~cs_n;
endmodule

// File: rtl/spi_id_checker.sv
module spi_id_checker
    import spi_id_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      so_out,
    input logic      so_oe,
    input logic      sck_fall,
    input id_state_e state
);
    assert_release_when_deselected_R1: assert property (
        @(posedge clk) disable iff (!rst_n) cs_n |-> !so_oe);

    assert_quiet_while_receiving_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((state == ST_CMD) || (state == ST_ADDR)) |-> !so_oe);

    assert_restart_on_deselect_R9: assert property (
        @(posedge clk) disable iff (!rst_n) cs_n |=> (state == ST_CMD));

    assert_skip_stays_released_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (state == ST_SKIP) |-> !so_oe);

    assert_change_only_after_fall_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so_out));
endmodule

bind spi_id_responder spi_id_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .so_out   (so_out),
    .so_oe    (so_oe),
    .sck_fall (sck_fall),
    .state    (state)
);

// File: tb/spi_id_responder_test.sv
module spi_id_responder_test;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so_out, so_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] got [0:15];
    logic       got_oe [0:15];
    bit         rx_oe_seen;

    always #2 clk = ~clk;

    spi_id_responder uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (sck),
        .cs_n   (cs_n),
        .si     (si),
        .so_out (so_out),
        .so_oe  (so_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic a0, input int k);
        if (op == 8'h9F) begin
            case (k)
                0: return 8'hBF;
                1: return 8'h25;
                2: return 8'h8D;
                default: return 8'h00;
            endcase
        end
        return ((k % 2 == 1) ^ a0) ? 8'h8D : 8'hBF;
    endfunction

    function automatic bit is_known(input logic [7:0] op);
        return (op == 8'h9F) || (op == 8'h90) || (op == 8'hAB);
    endfunction

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0; si = b; wait_half();
        if (so_oe) rx_oe_seen = 1'b1;
        sck = 1'b1; wait_half();
        if (so_oe) rx_oe_seen = 1'b1;
    endtask

    // one frame; reads nbits output bits, then deselects
    task automatic frame(input logic [7:0] op, input logic [23:0] addr,
                         input int nbits, input bit mode3);
        logic [7:0] sh;
        sck = mode3; wait_half();
        cs_n = 1'b0; rx_oe_seen = 1'b0; wait_half();
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
        if (op == 8'h90 || op == 8'hAB)
            for (int i = 23; i >= 0; i--) send_bit(addr[i]);
        sh = '0;
        for (int b = 0; b < nbits; b++) begin
            sck = 1'b0; wait_half();
            sh = {sh[6:0], so_out};
            if (b % 8 == 0) got_oe[b/8] = so_oe;
            else got_oe[b/8] = got_oe[b/8] & so_oe;
            if (b % 8 == 7) got[b/8] = sh;
            sck = 1'b1; wait_half();
        end
        if (!mode3) begin sck = 1'b0; wait_half(); end
        cs_n = 1'b1;
        #1;
        check(so_oe == 1'b0, "R9 oe drop on deselect", so_oe, 0);
        check(rx_oe_seen == 1'b0, "R2 quiet during receive", rx_oe_seen, 0);
        wait_half();
    endtask

    task automatic run_and_check(input logic [7:0] op, input logic [23:0] addr,
                                 input int nbytes, input bit mode3, input string req);
        frame(op, addr, nbytes * 8, mode3);
        for (int k = 0; k < nbytes; k++) begin
            if (is_known(op)) begin
                check(got_oe[k] == 1'b1, {req, " oe"}, got_oe[k], 1);
                check(got[k] == exp_byte(op, addr[0], k), req, got[k], exp_byte(op, addr[0], k));
            end else begin
                check(got_oe[k] == 1'b0, {req, " R10 unknown op released"}, got_oe[k], 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(so_oe == 1'b0, "R1 reset released", so_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(so_oe == 1'b0, "R1 idle released", so_oe, 0);

        // R3, R11 mode 0 and R12 sampling on rise
        run_and_check(8'h9F, 24'h0, 3, 1'b0, "R3 jedec mode0");
        // R4 zero tail, R11 mode 3
        run_and_check(8'h9F, 24'h0, 6, 1'b1, "R4 jedec tail mode3");
        // R5 start with manufacturer, R7 alternation
        run_and_check(8'h90, 24'h000000, 5, 1'b0, "R5 R7 legacy a0=0");
        // R6 start with device
        run_and_check(8'hAB, 24'h000001, 5, 1'b1, "R6 R7 legacy a0=1");
        // R8 upper address bits ignored
        run_and_check(8'h90, 24'hFFFFFE, 3, 1'b1, "R8 upper bits set a0=0");
        run_and_check(8'hAB, 24'h5A3C01, 3, 1'b0, "R8 upper bits random a0=1");
        // R10 unknown instruction
        run_and_check(8'h03, 24'h0, 2, 1'b0, "R10 op 03");
        run_and_check(8'h9E, 24'h0, 2, 1'b1, "R10 op 9E");
        // R9 abort part-way, then a fresh frame decodes correctly
        frame(8'h9F, 24'h0, 12, 1'b0);
        run_and_check(8'h9F, 24'h0, 3, 1'b0, "R9 fresh after abort");
        frame(8'hAB, 24'h000001, 5, 1'b1);
        run_and_check(8'h90, 24'h000000, 2, 1'b0, "R9 fresh legacy after abort");

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] op;
            logic [23:0] addr;
            int sel, nb;
            bit m3;
            sel  = int'($urandom_range(0, 3));
            op   = (sel == 0) ? 8'h9F : (sel == 1) ? 8'h90 : (sel == 2) ? 8'hAB : 8'($urandom);
            addr = 24'($urandom);
            nb   = int'($urandom_range(1, 6));
            m3   = 1'($urandom);
            run_and_check(op, addr, nb, m3, "R3 R4 R5 R6 R7 R8 R10 R11 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule